// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Controller

This block keeps the interrupt bookkeeping of a real-time clock. It receives three kinds of event from the surrounding timekeeping logic. The first is a one-cycle periodic tick from the selected divider tap. The second is a one-cycle pulse that marks the end of each time update. The third is the current hours, minutes and seconds bytes. It also receives the three alarm bytes from the register file. From these events it keeps a periodic flag, an alarm flag and an update-ended flag. Each flag sets on its event even when the matching interrupt enable is off. A summary request flag and an active-low interrupt line follow whichever enabled flags are pending.

Software reaches the block through two ports. One is a write/read port for a control register that holds the three interrupt enables, the update-hold bit, the data-format bit and the hour-format bit. The other is a read strobe for the status register. Reading the status register returns the flags as they stood and clears them on the following edge. The alarm comparison runs once per update-ended pulse. So while the time matches, the alarm can fire at most once per update. Any alarm byte whose two top bits are both 1 acts as a wildcard.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: The status read data carries the summary request flag at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update-ended flag at bit 4. Bits 3 down to 0 are always 0.
- R2: The control read data holds the update-hold bit (bit 7), the periodic enable (bit 6), the alarm enable (bit 5), the update-ended enable (bit 4), the data-format bit (bit 2) and the hour-format bit (bit 1). Bits 3 and 0 always read 0. Every other written bit reads back, except as R9 states.
- R3: The summary flag is 1 exactly when at least one flag is 1 together with its own enable. irq_n_o is low exactly when the summary flag is 1.
- R4: A periodic tick sets the periodic flag on the next clock edge, whatever the periodic enable holds.
- R5: An update-ended pulse sets the update-ended flag on the next clock edge.
- R6: On an update-ended pulse, the alarm flag sets when every time byte equals its alarm byte. An alarm byte with 11 in its top two bits matches any time byte. With no match, or with no pulse, the alarm flag is left unchanged.
- R7: A status read returns the flag values from before the read. All flags are cleared on the next edge, except that an event arriving in the same cycle sets its flag again.
- R8: Reset clears all flags, the three enables and the update-hold bit, so irq_n_o is high. The data-format and hour-format bits keep their values through reset.
- R9: A control write that takes the update-hold bit from 0 to 1 also clears the update-ended enable, whatever value is written to that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| periodic_tick_i | input | 1 | One-cycle pulse at the selected periodic rate |
| update_done_i | input | 1 | One-cycle pulse at the end of each time update |
| sec_i | input | 8 | Current seconds byte |
| min_i | input | 8 | Current minutes byte |
| hr_i | input | 8 | Current hours byte |
| alm_sec_i | input | 8 | Seconds alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_hr_i | input | 8 | Hours alarm byte |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| stat_rd_i | input | 1 | Status register read strobe (clears flags) |
| stat_rdata_o | output | 8 | Status register read data |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions assume the following about the inputs:
- the tick and update pulses last a single cycle, and each is sampled at the edge where it is high;
- nothing arrives during the two cycles in which the internal reset is still held after rst_n rises;
- a status read is seen as the cycle in which the strobe is high.

The stimulus drives every input on the falling edge and holds it for exactly one cycle. It stays idle for three cycles after each reset release. Time and alarm bytes are drawn from a small value set mixed with wildcard codes, so that alarm matches and mismatches both occur often.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_EVT = 3;

  // flag vector order; bit i of the vector lands at status bit FLAG_LSB+i
  localparam int EV_UPD = 0;
  localparam int EV_ALM = 1;
  localparam int EV_PER = 2;

  localparam int STAT_IRQ_BIT = 7;
  localparam int FLAG_LSB     = 4;

  localparam int CTL_HOLD_BIT = 7;
  localparam int CTL_PEN_BIT  = 6;
  localparam int CTL_AEN_BIT  = 5;
  localparam int CTL_UEN_BIT  = 4;
  localparam int CTL_FMT_BIT  = 2;
  localparam int CTL_H24_BIT  = 1;

  typedef struct packed {
    logic hold;
    logic pen;
    logic aen;
    logic uen;
    logic fmt;
    logic h24;
  } ctl_t;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3
) (
  input  logic [NUM_BYTES*BYTE_W-1:0] time_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] alarm_i,
  output logic                        match_o
);
  localparam int TOP = BYTE_W - 1;

  logic [NUM_BYTES-1:0] hit;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] t_b;
    logic [BYTE_W-1:0] a_b;
    logic              wild;
    assign t_b  = time_i[b*BYTE_W +: BYTE_W];
    assign a_b  = alarm_i[b*BYTE_W +: BYTE_W];
    assign wild = a_b[TOP] & a_b[TOP-1];
    assign hit[b] = wild | (a_b == t_b);
  end

  assign match_o = &hit;
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_d[i] = evt_i[i] | (flag_q[i] & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output ctl_t             ctl_o,
  output logic [REG_W-1:0] rdata_o
);
  logic hold_q, pen_q, aen_q, uen_q, fmt_q, h24_q;
  logic hold_d, pen_d, aen_d, uen_d;
  logic hold_rise;

  assign hold_rise = wr_i & wdata_i[CTL_HOLD_BIT] & ~hold_q;

  always_comb begin
    hold_d = hold_q;
    pen_d  = pen_q;
    aen_d  = aen_q;
    uen_d  = uen_q;
    if (wr_i) begin
      hold_d = wdata_i[CTL_HOLD_BIT];
      pen_d  = wdata_i[CTL_PEN_BIT];
      aen_d  = wdata_i[CTL_AEN_BIT];
      uen_d  = wdata_i[CTL_UEN_BIT] & ~hold_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      pen_q  <= 1'b0;
      aen_q  <= 1'b0;
      uen_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pen_q  <= pen_d;
      aen_q  <= aen_d;
      uen_q  <= uen_d;
    end
  end

  // format bits are kept through reset on purpose
  always_ff @(posedge clk) begin
    if (wr_i) begin
      fmt_q <= wdata_i[CTL_FMT_BIT];
      h24_q <= wdata_i[CTL_H24_BIT];
    end
  end

  assign ctl_o = '{hold: hold_q, pen: pen_q, aen: aen_q, uen: uen_q,
                   fmt: fmt_q, h24: h24_q};

  always_comb begin
    rdata_o               = '0;
    rdata_o[CTL_HOLD_BIT] = hold_q;
    rdata_o[CTL_PEN_BIT]  = pen_q;
    rdata_o[CTL_AEN_BIT]  = aen_q;
    rdata_o[CTL_UEN_BIT]  = uen_q;
    rdata_o[CTL_FMT_BIT]  = fmt_q;
    rdata_o[CTL_H24_BIT]  = h24_q;
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periodic_tick_i,
  input  logic              update_done_i,
  input  logic [BYTE_W-1:0] sec_i,
  input  logic [BYTE_W-1:0] min_i,
  input  logic [BYTE_W-1:0] hr_i,
  input  logic [BYTE_W-1:0] alm_sec_i,
  input  logic [BYTE_W-1:0] alm_min_i,
  input  logic [BYTE_W-1:0] alm_hr_i,
  input  logic              ctl_wr_i,
  input  logic [REG_W-1:0]  ctl_wdata_i,
  output logic [REG_W-1:0]  ctl_rdata_o,
  input  logic              stat_rd_i,
  output logic [REG_W-1:0]  stat_rdata_o,
  output logic              irq_n_o
);
  localparam int NUM_BYTES = 3;

  // reset: asserted at once, released after SYNC_LEN edges
  logic [SYNC_LEN-1:0] rst_pipe_q;
  logic                rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_LEN-1];

  ctl_t ctl;

  rtc_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl),
    .rdata_o (ctl_rdata_o)
  );

  logic alarm_hit;

  rtc_alarm_match #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_match (
    .time_i  ({hr_i, min_i, sec_i}),
    .alarm_i ({alm_hr_i, alm_min_i, alm_sec_i}),
    .match_o (alarm_hit)
  );

  logic [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] flags;
  logic [NUM_EVT-1:0] enables;

  always_comb begin
    evt         = '0;
    evt[EV_PER] = periodic_tick_i;
    evt[EV_ALM] = update_done_i & alarm_hit;
    evt[EV_UPD] = update_done_i;
  end

  rtc_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt_i  (evt),
    .clr_i  (stat_rd_i),
    .flag_o (flags)
  );

  always_comb begin
    enables         = '0;
    enables[EV_PER] = ctl.pen;
    enables[EV_ALM] = ctl.aen;
    enables[EV_UPD] = ctl.uen;
  end

  logic irq_req;
  assign irq_req = |(flags & enables);

  always_comb begin
    stat_rdata_o                              = '0;
    stat_rdata_o[STAT_IRQ_BIT]                = irq_req;
    stat_rdata_o[FLAG_LSB +: NUM_EVT]         = flags;
  end

  assign irq_n_o = ~irq_req;
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       periodic_tick_i,
  input logic       update_done_i,
  input logic       ctl_wr_i,
  input logic [7:0] ctl_wdata_i,
  input logic [7:0] ctl_rdata_o,
  input logic       stat_rd_i,
  input logic [7:0] stat_rdata_o,
  input logic       irq_n_o
);
  // R1
  low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata_o[3:0] == 4'h0);

  // R2
  ctl_fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata_o[3] == 1'b0) && (ctl_rdata_o[0] == 1'b0));

  // R3
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o == !stat_rdata_o[7]);

  // R3
  summary_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata_o[7] |-> |(stat_rdata_o[6:4] & ctl_rdata_o[6:4]));

  // R4
  periodic_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_tick_i |=> stat_rdata_o[6]);

  // R5
  update_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_done_i |=> stat_rdata_o[4]);

  // R6
  alarm_only_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!update_done_i && !stat_rdata_o[5]) |=> !stat_rdata_o[5]);

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !periodic_tick_i && !update_done_i) |=> (stat_rdata_o[6:4] == 3'b000));

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd_i && stat_rdata_o[6]) |=> stat_rdata_o[6]);

  // R9
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && ctl_wdata_i[7] && !ctl_rdata_o[7]) |=> !ctl_rdata_o[4]);
endmodule

bind rtc_irq_ctrl rtc_irq_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .periodic_tick_i (periodic_tick_i),
  .update_done_i   (update_done_i),
  .ctl_wr_i        (ctl_wr_i),
  .ctl_wdata_i     (ctl_wdata_i),
  .ctl_rdata_o     (ctl_rdata_o),
  .stat_rd_i       (stat_rd_i),
  .stat_rdata_o    (stat_rdata_o),
  .irq_n_o         (irq_n_o)
);

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, upd, ctl_wr, stat_rd;
  logic [7:0] sec, mn, hr, a_sec, a_min, a_hr, wdata;
  logic [7:0] ctl_rdata, stat_rdata;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rtc_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .periodic_tick_i(tick), .update_done_i(upd),
    .sec_i(sec), .min_i(mn), .hr_i(hr),
    .alm_sec_i(a_sec), .alm_min_i(a_min), .alm_hr_i(a_hr),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(wdata), .ctl_rdata_o(ctl_rdata),
    .stat_rd_i(stat_rd), .stat_rdata_o(stat_rdata), .irq_n_o(irq_n)
  );

  // reference state
  logic m_pf, m_af, m_uf, m_hold, m_pen, m_aen, m_uen, m_fmt, m_h24;

  function automatic logic byte_ok(input logic [7:0] t, input logic [7:0] a);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  function automatic logic [7:0] exp_stat();
    logic irq;
    irq = (m_pf & m_pen) | (m_af & m_aen) | (m_uf & m_uen);
    return {irq, m_pf, m_af, m_uf, 4'b0000};
  endfunction

  function automatic logic [7:0] exp_ctl();
    return {m_hold, m_pen, m_aen, m_uen, 1'b0, m_fmt, m_h24, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] es;
    es = exp_stat();
    chk("R1 status", stat_rdata, es);
    chk("R2 control", ctl_rdata, exp_ctl());
    chk("R3 irq line", {7'b0, irq_n}, {7'b0, ~es[7]});
  endtask

  task automatic idle_inputs();
    tick = 0; upd = 0; ctl_wr = 0; stat_rd = 0; wdata = 8'h00;
  endtask

  // one cycle: inputs already driven at negedge; model follows at posedge
  task automatic step();
    logic hr_rise;
    @(posedge clk);
    hr_rise = ctl_wr & wdata[7] & ~m_hold;
    m_pf = tick | (m_pf & ~stat_rd);
    m_uf = upd  | (m_uf & ~stat_rd);
    m_af = (upd & byte_ok(sec, a_sec) & byte_ok(mn, a_min) & byte_ok(hr, a_hr))
           | (m_af & ~stat_rd);
    if (ctl_wr) begin
      m_hold = wdata[7]; m_pen = wdata[6]; m_aen = wdata[5];
      m_uen = wdata[4] & ~hr_rise; m_fmt = wdata[2]; m_h24 = wdata[1];
    end
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    @(negedge clk);
    m_pf = 0; m_af = 0; m_uf = 0; m_hold = 0; m_pen = 0; m_aen = 0; m_uen = 0;
    rst_n = 1;
    for (int i = 0; i < 3; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] pick_time(input int r);
    return (r % 2 == 0) ? 8'h12 : 8'h34;
  endfunction

  function automatic logic [7:0] pick_alarm(input int r, input int s);
    case (r % 3)
      0:       return 8'h12;
      1:       return 8'h34;
      default: return 8'hC0 | 8'(s & 63);
    endcase
  endfunction

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0;
    idle_inputs();
    sec = 8'h00; mn = 8'h00; hr = 8'h00;
    a_sec = 8'h55; a_min = 8'h55; a_hr = 8'h55;
    m_fmt = 0; m_h24 = 0;
    do_reset();

    // R8: reset state of flags, enables and line
    chk("R8 reset status", stat_rdata, 8'h00);
    chk("R8 reset enables", ctl_rdata & 8'hF0, 8'h00);
    chk("R8 reset irq_n", {7'b0, irq_n}, 8'h01);

    // R2: write format bits and enables
    ctl_wr = 1; wdata = 8'b0000_0110; step();
    // R4: periodic flag sets with enable off, line stays high
    tick = 1; step();
    chk("R4 flag without enable", stat_rdata, 8'h40);
    chk("R4 irq_n stays high", {7'b0, irq_n}, 8'h01);
    ctl_wr = 1; wdata = 8'b0100_0110; step();
    chk("R3 summary with enable", stat_rdata, 8'hC0);
    // R7: read shows old value, then clears
    stat_rd = 1;
    chk("R7 read value", stat_rdata, 8'hC0);
    step();
    chk("R7 cleared", stat_rdata, 8'h00);
    // R7: event in same cycle as read survives
    tick = 1; step();
    stat_rd = 1; upd = 1; step();
    chk("R7 reset by read, set by event", stat_rdata, 8'h10);
    // R6: wildcard alarm on every byte
    a_sec = 8'hC3; a_min = 8'hFF; a_hr = 8'hD0; sec = 8'h07; mn = 8'h21; hr = 8'h09;
    stat_rd = 1; step();
    upd = 1; step();
    chk("R6 wildcard match", stat_rdata & 8'h20, 8'h20);
    // R6: one byte mismatched, no flag
    stat_rd = 1; step();
    a_hr = 8'h08; upd = 1; step();
    chk("R6 mismatch", stat_rdata & 8'h20, 8'h00);
    // R6: match but no update pulse
    a_hr = 8'h09; step();
    chk("R6 no pulse", stat_rdata & 8'h20, 8'h00);
    // R9: hold rise clears update enable
    ctl_wr = 1; wdata = 8'b1001_0000; step();
    chk("R9 hold rise", ctl_rdata & 8'hF0, 8'h80);
    ctl_wr = 1; wdata = 8'b1001_0000; step();
    chk("R9 hold already set", ctl_rdata & 8'hF0, 8'h90);
    // R8: format bits survive reset
    ctl_wr = 1; wdata = 8'b0111_0110; step();
    do_reset();
    chk("R8 format kept", ctl_rdata, 8'h06);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      tick    = ($urandom % 4) == 0;
      upd     = ($urandom % 5) == 0;
      stat_rd = ($urandom % 6) == 0;
      ctl_wr  = ($urandom % 10) == 0;
      wdata   = 8'($urandom);
      sec = pick_time($urandom); mn = pick_time($urandom); hr = pick_time($urandom);
      a_sec = pick_alarm($urandom, $urandom);
      a_min = pick_alarm($urandom, $urandom);
      a_hr  = pick_alarm($urandom, $urandom);
      step();
      if (c % 1000 == 999) begin
        do_reset();
        chk("R8 mid-run reset", stat_rdata, 8'h00);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule